// File: doc/BRIEF.md
# Pilot ID Tone Classifier

This block sorts a digitized identification tone into one of three broadcast sound modes: MONO, STEREO or BILINGUAL. The tone arrives as a logic-level square wave, already recovered from an AM-detected pilot sub-carrier and squared by a comparator. The block times each tone cycle as a count of system clocks between rising edges. It tests that period against two acceptance bands per tone identity. A narrow band is used to acquire a tone, and a wider band is used to keep it once held. Nominal tones are 150 Hz for STEREO and 276 Hz for BILINGUAL.

A candidate identity only becomes the reported mode after it has held without a break for a long entry dwell, about one second by default. A reported mode falls back to MONO after the tone has been absent or wrong without a break for a shorter exit dwell, about 0.3 second by default. The 2-bit mode code is meant for a status register that a host reads over a serial bus. An active-low output drives an open-drain pin that can sink indicator LED current directly. Every limit is derived from the `CLK_HZ` parameter, so a bench can run on a scaled clock.

Top module: `pilot_id_classifier`

## Requirements
- R1: While reset is asserted and directly after it, the mode code is 2'b00 (MONO) and `led_on_no` is 1 (released).
- R2: A STEREO candidate is taken up only from a period whose frequency lies in 140 Hz to 160 Hz. A 133 Hz or a 194 Hz tone heard from MONO never yields STEREO.
- R3: An established STEREO identity is kept while measured frequencies stay within 125 Hz to 176 Hz, the 125 Hz bound included.
- R4: A BILINGUAL candidate is taken up only from a period whose frequency lies in 255 Hz to 300 Hz. Tones at 194 Hz or 426 Hz from MONO leave the mode at MONO.
- R5: An established BILINGUAL identity is kept while measured frequencies stay within 237 Hz to 312 Hz.
- R6: The mode leaves MONO for STEREO (code 2'b01) or BILINGUAL (code 2'b10) only after the same candidate has been held for ENTRY_MS milliseconds of `CLK_HZ` clocks, and never sooner.
- R7: A non-MONO mode returns to MONO only after its identity has been missing for EXIT_MS milliseconds of clocks without a break, and never sooner.
- R8: If no rising edge arrives within one period of the lowest release frequency (125 Hz), the identity counts as lost. A rising edge that lands exactly one clock beyond that bound counts as an invalid period.
- R9: Code 2'b11 never appears. A change between STEREO and BILINGUAL always passes through MONO, with a full exit dwell followed by a full entry dwell.
- R10: `led_on_no` is 0 exactly when the mode code is not 2'b00.
- R11: If the candidate breaks before the entry dwell completes, the entry dwell restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock at CLK_HZ |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tone_i | input | 1 | Squared identification tone, asynchronous to clk_i |
| mode_code_o | output | 2 | 00 MONO, 01 STEREO, 10 BILINGUAL |
| led_on_no | output | 1 | Active-low LED sink enable for an open-drain pin |

## Verification
Two functions can land in the same clock cycle: the missing-edge timeout and a rising edge that closes a period. That happens when the period equals the 125 Hz bound plus one clock. The bench provokes it by first holding STEREO with a tone of exactly the bound period, which must keep the mode. It then switches to a tone one clock longer. The edge must take precedence and be classified as an invalid period, so the mode must fall to MONO inside the exit-dwell window. It must neither stay in STEREO nor leave early.

// File: rtl/pic_pkg.sv
package pic_pkg;

  typedef enum logic [1:0] {
    MODE_MONO   = 2'b00,
    MODE_STEREO = 2'b01,
    MODE_BILING = 2'b10
  } mode_e;

  // shortest period (clocks) of a tone at or below f_hz
  function automatic int per_min(longint clk_hz, longint f_hz);
    return int'((clk_hz + f_hz - 1) / f_hz);
  endfunction

  // longest period (clocks) of a tone at or above f_hz
  function automatic int per_max(longint clk_hz, longint f_hz);
    return int'(clk_hz / f_hz);
  endfunction

  function automatic int ms_to_cyc(longint clk_hz, longint ms);
    return int'((clk_hz * ms) / 1000);
  endfunction

endpackage

// File: rtl/pic_rst_sync.sv
module pic_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [1:0] stg_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) stg_q <= 2'b00;
    else          stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_no = stg_q[1];
endmodule

// File: rtl/pic_period_meter.sv
module pic_period_meter #(
  parameter int CNT_W = 10,
  parameter int TMO   = 513
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tone_i,
  output logic             meas_vld_o,
  output logic [CNT_W-1:0] meas_per_o,
  output logic             tmo_o
);
  localparam logic [CNT_W-1:0] TMO_C = CNT_W'(TMO);

  logic [2:0]       sync_q;
  logic             rise;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             ref_q, ref_d;
  logic             vld_q, vld_d;
  logic [CNT_W-1:0] per_q, per_d;
  logic             tmo_q, tmo_d;

  assign rise    = sync_q[1] & ~sync_q[2];
  assign cnt_inc = (cnt_q == TMO_C) ? cnt_q : cnt_q + 1'b1;

  always_comb begin
    cnt_d = cnt_inc;
    ref_d = ref_q;
    vld_d = 1'b0;
    per_d = per_q;
    tmo_d = 1'b0;
    if (rise) begin
      // edge wins over a timeout due in the same cycle
      vld_d = ref_q;
      per_d = cnt_inc;
      cnt_d = '0;
      ref_d = 1'b1;
    end else if (ref_q && (cnt_inc == TMO_C) && (cnt_q != TMO_C)) begin
      tmo_d = 1'b1;
      ref_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 3'b000;
      cnt_q  <= '0;
      ref_q  <= 1'b0;
      vld_q  <= 1'b0;
      per_q  <= '0;
      tmo_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], tone_i};
      cnt_q  <= cnt_d;
      ref_q  <= ref_d;
      vld_q  <= vld_d;
      if (rise) per_q <= per_d;
      tmo_q  <= tmo_d;
    end
  end

  assign meas_vld_o = vld_q;
  assign meas_per_o = per_q;
  assign tmo_o      = tmo_q;

  // R8: a reported period is never zero and never beyond the timeout bound
  a_r8_period_capped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_vld_o |-> (meas_per_o != '0 && meas_per_o <= TMO_C));
  // R8: timeout and a measurement never fire together
  a_r8_tmo_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |-> !meas_vld_o);
endmodule

// File: rtl/pic_window_judge.sv
module pic_window_judge
  import pic_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int SA_LO    = 400,
  parameter int SA_HI    = 457,
  parameter int SR_LO    = 364,
  parameter int SR_HI    = 512,
  parameter int BA_LO    = 214,
  parameter int BA_HI    = 250,
  parameter int BR_LO    = 206,
  parameter int BR_HI    = 270
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             meas_vld_i,
  input  logic [CNT_W-1:0] meas_per_i,
  input  logic             tmo_i,
  output mode_e            cand_o
);
  // window index: 0 stereo acquire, 1 stereo release, 2 bil acquire, 3 bil release
  localparam int NWIN = 4;
  localparam int LO_TAB [NWIN] = '{SA_LO, SR_LO, BA_LO, BR_LO};
  localparam int HI_TAB [NWIN] = '{SA_HI, SR_HI, BA_HI, BR_HI};

  logic [NWIN-1:0] in_win;
  mode_e           cand_q, cand_d;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    localparam logic [CNT_W-1:0] LO_C = CNT_W'(LO_TAB[w]);
    localparam logic [CNT_W-1:0] HI_C = CNT_W'(HI_TAB[w]);
    assign in_win[w] = (meas_per_i >= LO_C) && (meas_per_i <= HI_C);
  end

  always_comb begin
    cand_d = cand_q;
    if (tmo_i) begin
      cand_d = MODE_MONO;
    end else if (meas_vld_i) begin
      if (cand_q == MODE_STEREO && in_win[1])      cand_d = MODE_STEREO;
      else if (cand_q == MODE_BILING && in_win[3]) cand_d = MODE_BILING;
      else if (in_win[0])                          cand_d = MODE_STEREO;
      else if (in_win[2])                          cand_d = MODE_BILING;
      else                                         cand_d = MODE_MONO;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cand_q <= MODE_MONO;
    else         cand_q <= cand_d;
  end

  assign cand_o = cand_q;

  // R8: a timeout always drops the candidate
  a_r8_tmo_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_i |=> cand_q == MODE_MONO);
  // R3: a held stereo candidate survives a period inside its release band
  a_r3_keep_stereo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_vld_i && cand_q == MODE_STEREO && in_win[1]) |=> cand_q == MODE_STEREO);
  // R5: same for bilingual
  a_r5_keep_biling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_vld_i && cand_q == MODE_BILING && in_win[3]) |=> cand_q == MODE_BILING);
  // R2: the candidate only takes a new identity on a measurement
  a_r2_take_on_meas: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand_q != MODE_MONO && cand_q != $past(cand_q)) |-> $past(meas_vld_i));
endmodule

// File: rtl/pic_dwell_fsm.sv
module pic_dwell_fsm
  import pic_pkg::*;
#(
  parameter int DW_W      = 13,
  parameter int ENTRY_CYC = 6400,
  parameter int EXIT_CYC  = 1920
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  mode_e      cand_i,
  output logic [1:0] mode_o,
  output logic       led_no
);
  localparam logic [DW_W-1:0] ENTRY_M1 = DW_W'(ENTRY_CYC - 1);
  localparam logic [DW_W-1:0] EXIT_M1  = DW_W'(EXIT_CYC - 1);

  mode_e           mode_q, mode_d;
  mode_e           prev_q;
  logic [DW_W-1:0] dw_q, dw_d, lim;
  logic            led_q, led_d;
  logic            is_mono, cond, restart;

  always_comb begin
    is_mono = (mode_q == MODE_MONO);
    cond    = is_mono ? (cand_i != MODE_MONO) : (cand_i != mode_q);
    restart = !cond || (is_mono && (cand_i != prev_q));
    lim     = is_mono ? ENTRY_M1 : EXIT_M1;
    mode_d  = mode_q;
    dw_d    = dw_q;
    if (restart) begin
      dw_d = '0;
    end else if (dw_q == lim) begin
      mode_d = is_mono ? cand_i : MODE_MONO;
      dw_d   = '0;
    end else begin
      dw_d = dw_q + 1'b1;
    end
    led_d = (mode_d == MODE_MONO);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_MONO;
      prev_q <= MODE_MONO;
      dw_q   <= '0;
      led_q  <= 1'b1;
    end else begin
      mode_q <= mode_d;
      prev_q <= cand_i;
      dw_q   <= dw_d;
      led_q  <= led_d;
    end
  end

  assign mode_o = mode_q;
  assign led_no = led_q;

  // R9: the unused code never shows
  a_r9_code_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q != 2'b11);
  // R9: no direct hop between the two tone modes
  a_r9_via_mono: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_MONO && $past(mode_q) != MODE_MONO) |-> mode_q == $past(mode_q));
  // R6: entry goes to the identity the candidate held
  a_r6_entry_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_MONO && $past(mode_q) == MODE_MONO) |-> $past(cand_i) == mode_q);
  // R7: exit only while the held identity is absent
  a_r7_exit_when_lost: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_MONO && $past(mode_q) != MODE_MONO) |-> $past(cand_i) != $past(mode_q));
  // R10: LED sink tracks the mode
  a_r10_led_track: assert property (@(posedge clk_i) disable iff (!rst_ni)
    led_q == (mode_q == MODE_MONO));
endmodule

// File: rtl/pilot_id_classifier.sv
module pilot_id_classifier
  import pic_pkg::*;
#(
  parameter int CLK_HZ       = 250_000_000,
  parameter int ENTRY_MS     = 1000,
  parameter int EXIT_MS      = 300,
  parameter int ST_ACQ_LO_HZ = 140,
  parameter int ST_ACQ_HI_HZ = 160,
  parameter int ST_REL_LO_HZ = 125,
  parameter int ST_REL_HI_HZ = 176,
  parameter int BI_ACQ_LO_HZ = 255,
  parameter int BI_ACQ_HI_HZ = 300,
  parameter int BI_REL_LO_HZ = 237,
  parameter int BI_REL_HI_HZ = 312
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tone_i,
  output logic [1:0] mode_code_o,
  output logic       led_on_no
);
  // higher frequency -> shorter period: the high Hz limit gives the low period bound
  localparam int SA_LO = per_min(CLK_HZ, ST_ACQ_HI_HZ);
  localparam int SA_HI = per_max(CLK_HZ, ST_ACQ_LO_HZ);
  localparam int SR_LO = per_min(CLK_HZ, ST_REL_HI_HZ);
  localparam int SR_HI = per_max(CLK_HZ, ST_REL_LO_HZ);
  localparam int BA_LO = per_min(CLK_HZ, BI_ACQ_HI_HZ);
  localparam int BA_HI = per_max(CLK_HZ, BI_ACQ_LO_HZ);
  localparam int BR_LO = per_min(CLK_HZ, BI_REL_HI_HZ);
  localparam int BR_HI = per_max(CLK_HZ, BI_REL_LO_HZ);
  localparam int FLOOR_HZ  = (ST_REL_LO_HZ < BI_REL_LO_HZ) ? ST_REL_LO_HZ : BI_REL_LO_HZ;
  localparam int TMO       = per_max(CLK_HZ, FLOOR_HZ) + 1;
  localparam int CNT_W     = $clog2(TMO + 1);
  localparam int ENTRY_CYC = ms_to_cyc(CLK_HZ, ENTRY_MS);
  localparam int EXIT_CYC  = ms_to_cyc(CLK_HZ, EXIT_MS);
  localparam int MAX_DW    = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC;
  localparam int DW_W      = $clog2(MAX_DW + 1);

  logic             rst_sn;
  logic             meas_vld;
  logic [CNT_W-1:0] meas_per;
  logic             tmo;
  mode_e            cand;

  pic_rst_sync u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_sn)
  );

  pic_period_meter #(.CNT_W(CNT_W), .TMO(TMO)) u_meter (
    .clk_i      (clk_i),
    .rst_ni     (rst_sn),
    .tone_i     (tone_i),
    .meas_vld_o (meas_vld),
    .meas_per_o (meas_per),
    .tmo_o      (tmo)
  );

  pic_window_judge #(
    .CNT_W(CNT_W),
    .SA_LO(SA_LO), .SA_HI(SA_HI), .SR_LO(SR_LO), .SR_HI(SR_HI),
    .BA_LO(BA_LO), .BA_HI(BA_HI), .BR_LO(BR_LO), .BR_HI(BR_HI)
  ) u_judge (
    .clk_i      (clk_i),
    .rst_ni     (rst_sn),
    .meas_vld_i (meas_vld),
    .meas_per_i (meas_per),
    .tmo_i      (tmo),
    .cand_o     (cand)
  );

  pic_dwell_fsm #(.DW_W(DW_W), .ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC)) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_sn),
    .cand_i (cand),
    .mode_o (mode_code_o),
    .led_no (led_on_no)
  );
endmodule

// File: tb/pilot_id_classifier_tb.sv
`timescale 1ns/1ps
module pilot_id_classifier_tb;
  localparam int CLK_HZ   = 64000;   // scaled clock for dwell timing
  localparam int ENTRY_MS = 100;
  localparam int EXIT_MS  = 30;
  localparam int ENTRY_C  = 6400;
  localparam int EXIT_C   = 1920;
  localparam int TMO_C    = 513;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tone = 1'b0;
  logic [1:0] mode;
  logic       led_n;
  int         cyc = 0;
  int         checks = 0;
  int         fails = 0;

  typedef struct {
    logic [1:0] code;
    int         lo;
    int         hi;
    string      tag;
  } exp_t;
  exp_t exq[$];

  always #2 clk = ~clk;   // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  pilot_id_classifier #(.CLK_HZ(CLK_HZ), .ENTRY_MS(ENTRY_MS), .EXIT_MS(EXIT_MS)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tone_i      (tone),
    .mode_code_o (mode),
    .led_on_no   (led_n)
  );

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic push_exp(logic [1:0] code, int lo, int hi, string tag);
    exp_t e;
    e.code = code; e.lo = lo; e.hi = hi; e.tag = tag;
    exq.push_back(e);
  endtask

  task automatic tone_run(int per, int n);
    for (int i = 0; i < n; i++) begin
      tone = 1'b1;
      repeat (per / 2) @(negedge clk);
      tone = 1'b0;
      repeat (per - per / 2) @(negedge clk);
    end
  endtask

  task automatic idle(int n);
    tone = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic check_mode(logic [1:0] code, string tag);
    @(negedge clk);
    chk(mode == code, tag, "mode code", int'(mode), int'(code));
    chk(led_n == (code == 2'b00), "R10", "led sink", int'(led_n), int'(code == 2'b00));
  endtask

  // monitor: every mode change must match the head of the scoreboard
  initial begin
    logic [1:0] last;
    exp_t e;
    last = 2'b00;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (mode != last) begin
        if (exq.size() == 0) begin
          chk(1'b0, "R9", "unexpected mode change", int'(mode), int'(last));
        end else begin
          e = exq.pop_front();
          chk(mode == e.code, e.tag, "mode code at change", int'(mode), int'(e.code));
          chk(cyc >= e.lo && cyc <= e.hi, e.tag, "change cycle (expected low bound)", cyc, e.lo);
          chk(led_n == (mode == 2'b00), "R10", "led at change", int'(led_n), int'(mode == 2'b00));
        end
        last = mode;
      end
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int s;
    repeat (5) @(negedge clk);
    check_mode(2'b00, "R1");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_mode(2'b00, "R1");

    // R6/R2: 150 Hz stereo tone acquires after the entry dwell
    s = cyc;
    push_exp(2'b01, s + ENTRY_C, s + ENTRY_C + 3 * 426 + 16, "R6");
    tone_run(426, 25);
    check_mode(2'b01, "R2");

    // R3: 133 Hz drift stays inside the release band
    tone_run(480, 20);
    check_mode(2'b01, "R3");

    // R8/R7: tone vanishes, timeout then exit dwell
    s = cyc;
    push_exp(2'b00, s + EXIT_C, s + EXIT_C + TMO_C + 16, "R8");
    idle(4000);
    check_mode(2'b00, "R7");

    // R2: 133 Hz from MONO is outside the acquire band
    tone_run(480, 20);
    check_mode(2'b00, "R2");

    // R4/R6: 276 Hz bilingual tone
    s = cyc;
    push_exp(2'b10, s + ENTRY_C, s + ENTRY_C + 3 * 232 + 16, "R4");
    tone_run(232, 40);
    check_mode(2'b10, "R6");

    // R5: 241 Hz drift held
    tone_run(265, 30);
    check_mode(2'b10, "R5");

    // R9: bilingual to stereo via MONO
    s = cyc;
    push_exp(2'b00, s + EXIT_C, s + EXIT_C + 3 * 426 + 16, "R9");
    push_exp(2'b01, s + EXIT_C + ENTRY_C, s + EXIT_C + ENTRY_C + 4 * 426 + 32, "R9");
    tone_run(426, 30);
    check_mode(2'b01, "R9");

    // R3: exactly the 125 Hz period bound keeps stereo
    tone_run(512, 20);
    check_mode(2'b01, "R3");

    // R8: one clock past the bound, edge coincides with timeout
    s = cyc;
    push_exp(2'b00, s + EXIT_C, s + EXIT_C + 3 * TMO_C + 16, "R8");
    tone_run(513, 10);
    check_mode(2'b00, "R8");

    // R2/R4: between the windows and above them
    tone_run(330, 20);
    check_mode(2'b00, "R2");
    tone_run(150, 20);
    check_mode(2'b00, "R4");

    // R11: broken entry dwell restarts
    tone_run(426, 10);
    tone_run(330, 3);
    s = cyc;
    push_exp(2'b01, s + ENTRY_C, s + ENTRY_C + 3 * 426 + 16, "R11");
    tone_run(426, 10);
    check_mode(2'b00, "R11");
    tone_run(426, 20);
    check_mode(2'b01, "R6");

    idle(20);
    chk(exq.size() == 0, "R6", "pending expected changes", exq.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule